// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in a set of packed BCD bytes. A clock enable pulsing at the 32,768 Hz reference rate feeds a prescaler. The prescaler produces one advance per second. Each advance steps seconds, minutes, hours, weekday, date, month and year through a carry chain. The date rolls over according to the length of the current month, and February follows a leap-year rule in which every year divisible by four is a leap year.

A host reads and writes the eight byte registers through a flat address/data port. Reads are combinational. Writes take effect on the next clock edge. A halt flag in the top bit of the seconds byte stops timekeeping, and the block comes out of reset halted. Software writes the time and then clears the flag. Register 7 is a plain byte that software may use as it likes.

Top module: `bcd_calendar_counter`

## Requirements
- R1: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year and 7 control. Each time field holds the tens digit in bits 7:4 and the units digit in bits 3:0. After reset the registers read 0x80, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 and 0x00.
- R2: Bits that no field uses always read 0. Each address keeps only these bits: 0 keeps 0xFF (halt plus seconds), 1 keeps 0x7F, 2 keeps 0x3F, 3 keeps 0x07, 4 keeps 0x3F, 5 keeps 0x1F, 6 keeps 0xFF and 7 keeps 0xFF.
- R3: Bit 7 of address 0 is the halt flag, and reset sets it. While the flag is 1, no register advances, whatever enable pulses arrive.
- R4: While the block is running, the registers advance once for every PRESCALE cycles with tick_en high. A write to address 0 restarts this count, so the next advance comes a full PRESCALE enables after the write.
- R5: Seconds and minutes wrap from 0x59 to 0x00, and hours wrap from 0x23 to 0x00. A field advances only when the field below it wraps on the same advance.
- R6: The weekday steps by one each time the hours wrap, and it goes from 7 back to 1. The weekday value has no effect on any other field.
- R7: The date wraps to 0x01 after its last day and carries into the month. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, 0x28 or 0x29 for month 0x02, and 0x31 for every other month.
- R8: February ends on 0x29 when the BCD year is divisible by four (years 00, 04, …, 96) and on 0x28 otherwise.
- R9: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R10: A field that holds an out-of-range value counts with one rule. If the units digit is 9 or more, the units become 0 and the tens digit adds one, truncated to the field's tens width. Otherwise the units add one. The field wraps and carries only when it equals its rollover value exactly.
- R11: The control byte at address 7 reads back the value last written and has no effect on timekeeping.
- R12: When a write and an advance fall in the same cycle, the written register takes the written value, and every other register takes its advanced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Enable pulse at the 32,768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |

## Verification
The bench targets the two February boundaries and the year and month wrap at 99-12-31 23:59:59. A design that got these wrong would skip or duplicate 29 February, or it would fail to wrap the year. It also checks the prescaler restart after a seconds write: an uncleared prescaler advances early, less than one full second after the write. Other checks write out-of-range values and all-ones patterns to catch early wraps, stray carries and unused bits that read as 1. A write that lands in the same cycle as an advance catches a design that loses either the written value or the carry.

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

  logic [PW-1:0] presc;
  logic       halt;
  logic [7:0] sec, min, hr, dow, date, mon, yr, ctl;

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [3:0] tmask);
    logic [3:0] t, u;
    t = v[7:4];
    u = v[3:0];
    if (u >= 4'd9) begin
      u = 4'd0;
      t = (t + 4'd1) & tmask;
    end else begin
      u = u + 4'd1;
    end
    return {t, u};
  endfunction

  logic leap;
  logic [7:0] last_day;
  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic adv, c_min, c_hr, c_day, c_mon, c_yr;
  assign adv   = tick_en && !halt && (presc == PMAX);
  assign c_min = adv   && (sec  == 8'h59);
  assign c_hr  = c_min && (min  == 8'h59);
  assign c_day = c_hr  && (hr   == 8'h23);
  assign c_mon = c_day && (date == last_day);
  assign c_yr  = c_mon && (mon  == 8'h12);

  logic [7:0] sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n;
  assign sec_n  = (sec  == 8'h59)    ? 8'h00 : bcd_step(sec,  4'h7);
  assign min_n  = (min  == 8'h59)    ? 8'h00 : bcd_step(min,  4'h7);
  assign hr_n   = (hr   == 8'h23)    ? 8'h00 : bcd_step(hr,   4'h3);
  assign dow_n  = (dow  == 8'h07)    ? 8'h01 : ((dow + 8'd1) & 8'h07);
  assign date_n = (date == last_day) ? 8'h01 : bcd_step(date, 4'h3);
  assign mon_n  = (mon  == 8'h12)    ? 8'h01 : bcd_step(mon,  4'h1);
  assign yr_n   = (yr   == 8'h99)    ? 8'h00 : bcd_step(yr,   4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      halt  <= 1'b1;
      sec   <= 8'h00;
      min   <= 8'h00;
      hr    <= 8'h00;
      dow   <= 8'h01;
      date  <= 8'h01;
      mon   <= 8'h01;
      yr    <= 8'h00;
      ctl   <= 8'h00;
    end else begin
      if ((wr_en && addr == 3'd0) || halt) presc <= '0;
      else if (tick_en)                    presc <= (presc == PMAX) ? '0 : presc + 1'b1;
      if (adv)   sec  <= sec_n;
      if (c_min) min  <= min_n;
      if (c_hr)  hr   <= hr_n;
      if (c_day) dow  <= dow_n;
      if (c_day) date <= date_n;
      if (c_mon) mon  <= mon_n;
      if (c_yr)  yr   <= yr_n;
      if (wr_en) begin
        case (addr)
          3'd0: begin halt <= wdata[7]; sec <= wdata & 8'h7F; end
          3'd1: min  <= wdata & 8'h7F;
          3'd2: hr   <= wdata & 8'h3F;
          3'd3: dow  <= wdata & 8'h07;
          3'd4: date <= wdata & 8'h3F;
          3'd5: mon  <= wdata & 8'h1F;
          3'd6: yr   <= wdata;
          3'd7: ctl  <= wdata;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = {halt, sec[6:0]};
      3'd1: rdata = min;
      3'd2: rdata = hr;
      3'd3: rdata = dow;
      3'd4: rdata = date;
      3'd5: rdata = mon;
      3'd6: rdata = yr;
      3'd7: rdata = ctl;
    endcase
  end

  a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(yr)));

  a_r4_seconds_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (presc == '0));

  a_r5_minute_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(min) || $past(sec) == 8'h59));

  a_r6_weekday_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && dow >= 8'h01 && dow <= 8'h07) |=> (dow >= 8'h01 && dow <= 8'h07));

  a_r9_year_moves_after_december: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(yr) || $past(mon) == 8'h12));

  a_r2_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hr[7:6] == 2'b00 && date[7:6] == 2'b00 && mon[7:5] == 3'b000 && dow[7:3] == 5'b0));
endmodule

// File: tb/tb_bcd_calendar_counter.sv
`timescale 1ns/1ps
module tb_bcd_calendar_counter;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  always #2.5 clk = ~clk;

  bcd_calendar_counter #(.PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m [0:7];
  bit m_halt;
  int m_cnt;

  function automatic logic [7:0] keep_mask(input int a);
    case (a)
      0: return 8'h7F;
      1: return 8'h7F;
      2: return 8'h3F;
      3: return 8'h07;
      4: return 8'h3F;
      5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] step(input logic [7:0] v, input logic [3:0] tw);
    logic [3:0] hi = v[7:4];
    logic [3:0] lo = v[3:0];
    if (lo >= 4'd9) begin lo = 4'd0; hi = (hi + 4'd1) & tw; end
    else lo = lo + 4'd1;
    return {hi, lo};
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mo, input logic [7:0] y);
    int yv = int'(y[7:4]) * 10 + int'(y[3:0]);
    if (mo == 8'h02) return (yv % 4 == 0) ? 8'h29 : 8'h28;
    if (mo == 8'h04 || mo == 8'h06 || mo == 8'h09 || mo == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic model_second();
    logic [7:0] me;
    me = month_end(m[5], m[6]);
    if (m[0] != 8'h59) begin m[0] = step(m[0], 4'h7); return; end
    m[0] = 8'h00;
    if (m[1] != 8'h59) begin m[1] = step(m[1], 4'h7); return; end
    m[1] = 8'h00;
    if (m[2] != 8'h23) begin m[2] = step(m[2], 4'h3); return; end
    m[2] = 8'h00;
    m[3] = (m[3] == 8'h07) ? 8'h01 : ((m[3] + 8'd1) & 8'h07);
    if (m[4] != me) begin m[4] = step(m[4], 4'h3); return; end
    m[4] = 8'h01;
    if (m[5] != 8'h12) begin m[5] = step(m[5], 4'h1); return; end
    m[5] = 8'h01;
    m[6] = (m[6] == 8'h99) ? 8'h00 : step(m[6], 4'hF);
  endtask

  task automatic model_enable();
    if (m_halt) begin m_cnt = 0; return; end
    if (m_cnt == P - 1) begin m_cnt = 0; model_second(); end
    else m_cnt++;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #0.5;
      check(req, rdata, (a == 0) ? {m_halt, m[0][6:0]} : m[a]);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    m[a] = d & keep_mask(a);
    if (a == 0) begin m_halt = d[7]; m_cnt = 0; end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      model_enable();
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
    wr(0, s);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
    m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h00;
    m_halt = 1'b1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    pulses(5 * P);
    check_all("R3 halted");

    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
    pulses(P);
    check_all("R5 seconds");
    pulses(P);
    check_all("R8 leap feb28->29");
    check("R6 weekday 7->1", m[3], 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    pulses(P);
    check_all("R7 leap feb29->mar1");

    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    pulses(P);
    check_all("R8 nonleap feb28->mar1");
    check("R8 month", m[5], 8'h03);

    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    pulses(P);
    check_all("R9 year 99->00");

    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    pulses(P);
    check_all("R7 april 30");

    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    pulses(P - 1);
    addr = 3'd0; #0.5;
    check("R4 no advance before full count", rdata, 8'h10);
    wr(0, 8'h20);
    pulses(P - 1);
    addr = 3'd0; #0.5;
    check("R4 write restarts count", rdata, 8'h20);
    pulses(1);
    addr = 3'd0; #0.5;
    check("R4 advance after full count", rdata, 8'h21);

    for (int a = 1; a < 8; a++) wr(a, 8'hFF);
    wr(0, 8'hFF);
    check_all("R2 unused bits");

    set_time(8'h7A, 8'h58, 8'h03, 8'h02, 8'h35, 8'h02, 8'h01);
    pulses(3 * P);
    check_all("R10 invalid seconds");
    wr(0, 8'h59);
    pulses(P);
    check_all("R10 no early carry");
    pulses(6 * P);
    check_all("R10 invalid date counts");

    wr(7, 8'hA5);
    pulses(7 * P);
    check_all("R11 control byte");

    set_time(8'h59, 8'h10, 8'h05, 8'h02, 8'h11, 8'h06, 8'h40);
    pulses(P - 1);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h33;
    model_enable();
    m[1] = 8'h33;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    check_all("R12 write beats advance");

    for (int it = 0; it < 40; it++) begin
      set_time(to_bcd($urandom % 60), to_bcd($urandom % 60), to_bcd($urandom % 24),
               8'(1 + $urandom % 7), to_bcd(1 + $urandom % 31), to_bcd(1 + $urandom % 12),
               to_bcd($urandom % 100));
      pulses(1 + $urandom % (P * 200));
      check_all("R5 R7 random run");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule